// File: doc/BRIEF.md
# Four-Phase Machine-Cycle Sequencer

This block is the timing backbone of a small 8-bit processor core. Every machine cycle is split into four phase steps, and the sequencer counts them with a 2-bit phase counter. From that count it issues single-clock strobes. They tell the rest of the core when to take the opcode from memory and the internal bus, when to load the instruction register, and when to register the decoded controls. They also set the moment to start the ALU, to write the result back, and to commit a data memory transfer. Each action has one fixed phase slot, so the datapath never needs a second clock edge or an inverted clock.

The decoder supplies two flags that it holds stable for a whole machine cycle. One says the current cycle moves data to or from memory. The other says the current cycle is the last of the instruction. When the last cycle leaves memory idle, the opcode of the next instruction is fetched in that same cycle, overlapped with execution. When the last cycle uses memory, the sequencer inserts a separate fetch cycle. A machine-cycle counter tells the decoder which step of the instruction is running. It reads 0 in a fetch cycle and counts 1, 2, 3 and so on in execute cycles.

Top module: `mcycle_sequencer`

## Requirements
- R1: `phase_o` steps 0, 1, 2, 3 and back to 0, advancing by one on every clock edge outside reset.
- R2: While `rst` is high, on the edge that follows, `phase_o` and `mcycle_o` are 0 and all strobes are low. The machine cycle that begins with that phase 0 is a plain fetch cycle: no control, ALU, write-back or memory-commit strobe occurs in it, while `op_read_o` and `op_bus_o` do occur.
- R3: `ir_load_o` is high only in phase 0, and exactly when the machine cycle just finished fetched an opcode (a fetch cycle, or an overlapped last execute cycle).
- R4: `ctl_latch_o` is high in phase 1 of every execute cycle and never in a fetch cycle.
- R5: `alu_start_o` is high in phase 2 of every execute cycle and at no other time.
- R6: `wb_commit_o` is high in phase 3 of every execute cycle, and it is never high in the same clock as `alu_start_o`.
- R7: `mem_commit_o` is high in phase 3 of an execute cycle whose `mem_acc_i` is 1. In a fetch cycle `mem_acc_i` is ignored.
- R8: In an execute cycle with `instr_done_i`=1 and `mem_acc_i`=0, `op_read_o` is high in phase 2 and `op_bus_o` in phase 3. The next machine cycle is then an execute cycle with `mcycle_o`=1, opened by `ir_load_o`.
- R9: In an execute cycle with `instr_done_i`=1 and `mem_acc_i`=1, no opcode strobe occurs. The next machine cycle is a fetch cycle (`mcycle_o`=0) that raises `op_read_o` in phase 2 and `op_bus_o` in phase 3, and it is followed by an execute cycle with `mcycle_o`=1.
- R10: After an execute cycle with `instr_done_i`=0, `mcycle_o` goes up by one at the phase-3-to-0 edge and saturates at 2**MCYC_W-1. `mcycle_o` changes only at that edge.
- R11: `instr_done_i` is ignored in a fetch cycle; a fetch cycle is always followed by an execute cycle with `mcycle_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge only |
| rst | input | 1 | Synchronous active-high reset |
| mem_acc_i | input | 1 | Current machine cycle moves data to or from memory (held stable for the cycle) |
| instr_done_i | input | 1 | Current machine cycle is the last of the instruction (held stable for the cycle) |
| phase_o | output | 2 | Phase step within the machine cycle |
| mcycle_o | output | MCYC_W | Machine cycle within the instruction, 0 for a fetch cycle |
| ir_load_o | output | 1 | Instruction register takes the opcode from the internal bus |
| ctl_latch_o | output | 1 | Decoded controls are registered |
| alu_start_o | output | 1 | ALU operation starts |
| wb_commit_o | output | 1 | ALU result is written back to the register file |
| mem_commit_o | output | 1 | Data memory read or write is committed |
| op_read_o | output | 1 | Next opcode is presented on the memory data output |
| op_bus_o | output | 1 | Opcode is moved onto the internal data bus |

## Verification
The bench builds the sequencer with MCYC_W=2, so the counter saturates at 3. Any instruction of four or more execute cycles therefore tests the saturation limit. The narrow counter also lets random instruction lengths cover the full counter range, including repeated saturation, in a short run. Directed cycles open the run with a fetch cycle that has both flags set, which tests R11. They then chain inserted fetches and overlapped fetches back to back, and a reset in the middle of a machine cycle checks that the sequencer restarts cleanly on a fetch.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int PH_W   = 2;
  localparam int N_SLOT = 1 << PH_W;

  typedef logic [PH_W-1:0] phase_t;

  // fixed datapath slots inside one machine cycle
  localparam phase_t SLOT_IR  = phase_t'(0);
  localparam phase_t SLOT_CTL = phase_t'(1);
  localparam phase_t SLOT_ALU = phase_t'(2);
  localparam phase_t SLOT_WB  = phase_t'(N_SLOT - 1);

  typedef enum logic {
    MC_FETCH = 1'b0,
    MC_EXEC  = 1'b1
  } mc_kind_e;
endpackage

// File: rtl/mseq_phase_ctr.sv
module mseq_phase_ctr
  import mseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase_o,
  output logic   wrap_o
);
  phase_t ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= SLOT_IR;
    else     ph_q <= ph_q + phase_t'(1);
  end

  assign phase_o = ph_q;
  assign wrap_o  = (ph_q == SLOT_WB);
endmodule

// File: rtl/mseq_cycle_track.sv
module mseq_cycle_track
  import mseq_pkg::*;
#(
  parameter int MCYC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_i,
  input  logic              mem_acc_i,
  input  logic              instr_done_i,
  output mc_kind_e          kind_o,
  output logic [MCYC_W-1:0] mcycle_o,
  output logic              fetching_o
);
  localparam logic [MCYC_W-1:0] MC_ZERO  = '0;
  localparam logic [MCYC_W-1:0] MC_FIRST = MCYC_W'(1);
  localparam logic [MCYC_W-1:0] MC_LAST  = '1;

  mc_kind_e          kind_q, kind_n;
  logic [MCYC_W-1:0] mc_q, mc_n;

  // this cycle brings in an opcode: either a dedicated fetch, or the
  // last execute cycle overlapping it because memory is otherwise idle
  always_comb begin
    fetching_o = (kind_q == MC_FETCH) || (instr_done_i && !mem_acc_i);
  end

  always_comb begin
    kind_n = kind_q;
    mc_n   = mc_q;
    if (kind_q == MC_FETCH) begin
      kind_n = MC_EXEC;
      mc_n   = MC_FIRST;
    end else if (instr_done_i) begin
      if (mem_acc_i) begin
        kind_n = MC_FETCH;
        mc_n   = MC_ZERO;
      end else begin
        kind_n = MC_EXEC;
        mc_n   = MC_FIRST;
      end
    end else begin
      kind_n = MC_EXEC;
      mc_n   = (mc_q == MC_LAST) ? MC_LAST : mc_q + MC_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= MC_FETCH;
      mc_q   <= MC_ZERO;
    end else if (wrap_i) begin
      kind_q <= kind_n;
      mc_q   <= mc_n;
    end
  end

  assign kind_o   = kind_q;
  assign mcycle_o = mc_q;
endmodule

// File: rtl/mseq_strobe_gen.sv
module mseq_strobe_gen
  import mseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  phase_t   phase_i,
  input  mc_kind_e kind_i,
  input  logic     mem_acc_i,
  input  logic     fetching_i,
  output logic     ir_load_o,
  output logic     ctl_latch_o,
  output logic     alu_start_o,
  output logic     wb_commit_o,
  output logic     mem_commit_o,
  output logic     op_read_o,
  output logic     op_bus_o
);
  // enter[s] : the next clock belongs to slot s
  logic [N_SLOT-1:0] enter;
  logic              exec;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_enter
    assign enter[g] = (phase_i == phase_t'((g + N_SLOT - 1) % N_SLOT));
  end

  assign exec = (kind_i == MC_EXEC);

  // strobes are registered one edge ahead so they line up with the slot
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_load_o    <= 1'b0;
      ctl_latch_o  <= 1'b0;
      alu_start_o  <= 1'b0;
      wb_commit_o  <= 1'b0;
      mem_commit_o <= 1'b0;
      op_read_o    <= 1'b0;
      op_bus_o     <= 1'b0;
    end else begin
      ir_load_o    <= enter[SLOT_IR]  & fetching_i;
      ctl_latch_o  <= enter[SLOT_CTL] & exec;
      alu_start_o  <= enter[SLOT_ALU] & exec;
      wb_commit_o  <= enter[SLOT_WB]  & exec;
      mem_commit_o <= enter[SLOT_WB]  & exec & mem_acc_i;
      op_read_o    <= enter[SLOT_ALU] & fetching_i;
      op_bus_o     <= enter[SLOT_WB]  & fetching_i;
    end
  end
endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mseq_pkg::*;
#(
  parameter int MCYC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_acc_i,
  input  logic              instr_done_i,
  output logic [1:0]        phase_o,
  output logic [MCYC_W-1:0] mcycle_o,
  output logic              ir_load_o,
  output logic              ctl_latch_o,
  output logic              alu_start_o,
  output logic              wb_commit_o,
  output logic              mem_commit_o,
  output logic              op_read_o,
  output logic              op_bus_o
);
  phase_t   phase;
  logic     wrap;
  mc_kind_e kind;
  logic     fetching;

  mseq_phase_ctr u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  mseq_cycle_track #(.MCYC_W(MCYC_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .wrap_i       (wrap),
    .mem_acc_i    (mem_acc_i),
    .instr_done_i (instr_done_i),
    .kind_o       (kind),
    .mcycle_o     (mcycle_o),
    .fetching_o   (fetching)
  );

  mseq_strobe_gen u_strobe (
    .clk          (clk),
    .rst          (rst),
    .phase_i      (phase),
    .kind_i       (kind),
    .mem_acc_i    (mem_acc_i),
    .fetching_i   (fetching),
    .ir_load_o    (ir_load_o),
    .ctl_latch_o  (ctl_latch_o),
    .alu_start_o  (alu_start_o),
    .wb_commit_o  (wb_commit_o),
    .mem_commit_o (mem_commit_o),
    .op_read_o    (op_read_o),
    .op_bus_o     (op_bus_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int MCYC_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_acc_i,
  input logic              instr_done_i,
  input logic [1:0]        phase_o,
  input logic [MCYC_W-1:0] mcycle_o,
  input logic              ir_load_o,
  input logic              ctl_latch_o,
  input logic              alu_start_o,
  input logic              wb_commit_o,
  input logic              mem_commit_o,
  input logic              op_read_o,
  input logic              op_bus_o
);
  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_o == 2'($past(phase_o) + 2'd1)));

  // R3
  ir_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load_o |-> (phase_o == 2'd0));

  // R4
  ctl_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_latch_o |-> (phase_o == 2'd1 && mcycle_o != '0));

  // R5
  alu_slot_chk: assert property (@(posedge clk) disable iff (rst)
    alu_start_o |-> (phase_o == 2'd2));

  // R6
  alu_wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(alu_start_o && wb_commit_o));

  // R7
  mem_slot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_commit_o |-> (phase_o == 2'd3 && wb_commit_o));

  // R8
  op_pair_chk: assert property (@(posedge clk) disable iff (rst)
    op_read_o |=> op_bus_o);

  // R8
  overlap_next_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3 && mcycle_o != '0 && instr_done_i && !mem_acc_i)
      |=> (mcycle_o == MCYC_W'(1) && ir_load_o));

  // R9
  insert_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3 && mcycle_o != '0 && instr_done_i && mem_acc_i)
      |=> (mcycle_o == '0 && !ir_load_o));

  // R10
  mcycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'd3) |=> $stable(mcycle_o));
endmodule

bind mcycle_sequencer mseq_chk #(.MCYC_W(MCYC_W)) u_mseq_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_acc_i    (mem_acc_i),
  .instr_done_i (instr_done_i),
  .phase_o      (phase_o),
  .mcycle_o     (mcycle_o),
  .ir_load_o    (ir_load_o),
  .ctl_latch_o  (ctl_latch_o),
  .alu_start_o  (alu_start_o),
  .wb_commit_o  (wb_commit_o),
  .mem_commit_o (mem_commit_o),
  .op_read_o    (op_read_o),
  .op_bus_o     (op_bus_o)
);

// File: tb/test_mcycle_sequencer.sv
`timescale 1ns/1ps
module test_mcycle_sequencer;
  localparam int MCYC_W = 2;
  localparam int MC_MAX = (1 << MCYC_W) - 1;
  localparam int N_MC   = 4000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mem_acc_i = 1'b0;
  logic              instr_done_i = 1'b0;
  logic [1:0]        phase_o;
  logic [MCYC_W-1:0] mcycle_o;
  logic ir_load_o, ctl_latch_o, alu_start_o, wb_commit_o;
  logic mem_commit_o, op_read_o, op_bus_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference state
  int e_ph = 0;
  bit e_fetch = 1;
  int e_mc = 0;
  bit e_irpend = 0;

  always #4 clk = ~clk;

  mcycle_sequencer #(.MCYC_W(MCYC_W)) i_mcycle_sequencer (
    .clk          (clk),
    .rst          (rst),
    .mem_acc_i    (mem_acc_i),
    .instr_done_i (instr_done_i),
    .phase_o      (phase_o),
    .mcycle_o     (mcycle_o),
    .ir_load_o    (ir_load_o),
    .ctl_latch_o  (ctl_latch_o),
    .alu_start_o  (alu_start_o),
    .wb_commit_o  (wb_commit_o),
    .mem_commit_o (mem_commit_o),
    .op_read_o    (op_read_o),
    .op_bus_o     (op_bus_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cyc_fetches(bit is_fetch, bit done, bit mem);
    return is_fetch || (done && !mem);
  endfunction

  // advance the reference by one clock edge
  task automatic model_step();
    if (rst) begin
      e_ph = 0; e_fetch = 1; e_mc = 0; e_irpend = 0;
    end else begin
      if (e_ph == 3) begin
        e_irpend = cyc_fetches(e_fetch, instr_done_i, mem_acc_i);
        if (e_fetch) begin
          e_fetch = 0; e_mc = 1;                 // R11
        end else if (instr_done_i && mem_acc_i) begin
          e_fetch = 1; e_mc = 0;                 // R9
        end else if (instr_done_i) begin
          e_fetch = 0; e_mc = 1;                 // R8
        end else begin
          e_mc = (e_mc == MC_MAX) ? MC_MAX : e_mc + 1;  // R10
        end
      end
      e_ph = (e_ph + 1) % 4;
    end
  endtask

  task automatic verify();
    bit ex;
    bit fx;
    ex = !e_fetch;
    fx = cyc_fetches(e_fetch, instr_done_i, mem_acc_i);
    if (rst) begin
      chk("R2 phase in reset", phase_o, 0);
      chk("R2 mcycle in reset", mcycle_o, 0);
      chk("R2 strobes in reset",
          {ir_load_o, ctl_latch_o, alu_start_o, wb_commit_o,
           mem_commit_o, op_read_o, op_bus_o}, 0);
    end else begin
      chk("R1 phase", phase_o, e_ph);
      chk("R10 R11 mcycle", mcycle_o, e_mc);
      chk("R3 ir_load", ir_load_o, (e_ph == 0) && e_irpend);
      chk("R4 ctl_latch", ctl_latch_o, (e_ph == 1) && ex);
      chk("R5 alu_start", alu_start_o, (e_ph == 2) && ex);
      chk("R6 wb_commit", wb_commit_o, (e_ph == 3) && ex);
      chk("R6 alu/wb exclusive", alu_start_o && wb_commit_o, 0);
      chk("R7 mem_commit", mem_commit_o, (e_ph == 3) && ex && mem_acc_i);
      chk("R8 R9 op_read", op_read_o, (e_ph == 2) && fx);
      chk("R8 R9 op_bus", op_bus_o, (e_ph == 3) && fx);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    verify();
  endtask

  // directed machine cycles: {mem, done}
  function automatic logic [1:0] directed(int k);
    case (k)
      0:  return 2'b11;  // fetch cycle, both flags ignored (R11, R7)
      1:  return 2'b10;  // exec mc1, memory, not done
      2:  return 2'b10;  // mc2
      3:  return 2'b00;  // mc3
      4:  return 2'b00;  // saturated at 3
      5:  return 2'b11;  // done with memory -> inserted fetch (R9)
      6:  return 2'b01;  // fetch cycle, done ignored
      7:  return 2'b01;  // exec mc1 done, overlap (R8)
      8:  return 2'b01;  // back-to-back overlap
      9:  return 2'b11;  // single-cycle with memory -> fetch
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst = 1'b0;
    for (int k = 0; k < N_MC; k++) begin
      logic [1:0] sel;
      if (k == 2000) begin
        tick(); tick();
        rst = 1'b1;      // reset in the middle of a machine cycle (R2)
        tick(); tick();
        rst = 1'b0;
      end
      if (k < 10) sel = directed(k);
      else        sel = 2'($urandom_range(0, 3));
      mem_acc_i    = sel[1];
      instr_done_i = sel[0];
      repeat (4) tick();
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule